// File: doc/BRIEF.md
# Duty-Ratio Overload Cutoff

This block sits between a pulse-width modulator and the drive input of a switching power stage. It protects against a modulator that reports a mark fraction far too high, or one that is stuck in the mark state. The incoming PWM line, nominally switching near 65 kHz, is first resynchronised to the system clock. Every period, measured from one rising edge to the next, is timed with two system-clock counters: one for high time and one for low time. A period counts as an excess when its high time is strictly more than 70 percent of the period, that is when `10*high > 7*(high+low)`. If no rising edge arrives within `TIMEOUT_CLKS` clocks, the elapsed span is closed as a synthetic period at the level the line is held at. A line held high therefore keeps producing excess periods, and a line held low keeps producing compliant ones.

A small state machine counts consecutive excess periods. Its states are `ST_RUN` (no streak), `ST_WATCH` (a streak is building) and `ST_TRIP` (drive removed). Its transitions are: RUN to WATCH on an excess period; RUN to TRIP on an excess period when the window is one; WATCH to WATCH on an excess period that leaves the count below the window; WATCH to TRIP when the count reaches the window; WATCH to RUN on a compliant period; and any state to RUN on `clear`. Reset also returns the machine to RUN. The window length is held in a 16-bit register loaded through `win_wr`/`win_val`. Its reset value, `WIN_DEFAULT`, covers a few cycles of a 300 Hz modulation tone at the nominal switching rate, so that one bad audio cycle is tolerated but a sustained fault is not.

Top module: `duty_trip_guard`

## Requirements
- R1: After reset, `drive_en` is 1, `fault` is 0 and the window register holds `WIN_DEFAULT`.
- R2: A period is an excess only when `10*high > 7*(high+low)`. A period of exactly 70 percent high (14 high, 6 low) is compliant, and one of 15 high, 6 low is an excess.
- R3: The block trips only when the number of consecutive excess periods reaches the window length. One fewer excess period leaves `drive_en` at 1, and a single excess period never trips a window of 2 or more.
- R4: Any compliant period resets the streak of excess periods to zero.
- R5: A window value of 0 behaves as a window of 1.
- R6: A line held high with no rising edge for `TIMEOUT_CLKS` clocks yields one excess period per timeout. A stuck-high line therefore trips after the window's count of timeouts.
- R7: A line held low with no rising edge yields compliant periods only, so a stuck-low line never trips.
- R8: Once tripped, `drive_en` stays 0 and `fault` stays 1 whatever the PWM line does, until `clear` or reset.
- R9: A one-cycle `clear` returns the block to `ST_RUN` with the streak at zero, so `drive_en` is 1 in the next cycle. `clear` takes priority over an excess period in the same cycle.
- R10: `fault` is always the inverse of `drive_en`.
- R11: A cycle with `win_wr` at 1 loads `win_val` into the window register, and the new value governs all later period evaluations.
- R12: The first rising edge after reset only starts timing and does not close a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_in | input | 1 | Modulator output being guarded (asynchronous) |
| win_wr | input | 1 | Load strobe for the window register |
| win_val | input | 16 | Window length to load |
| clear | input | 1 | Releases a trip and restarts the streak |
| drive_en | output | 1 | Enable to the power-stage drive; 0 removes drive |
| fault | output | 1 | High while the block is tripped |

## Verification
The assertions assume that `pwm_in` has no pulses narrower than one system clock. They also assume that `clear` and `win_wr` are synchronous, single-cycle strobes. The stimulus drives every input on the falling clock edge and holds each PWM level for at least one full clock. It builds each period from whole-clock high and low spans, so the measured counts match the bench's arithmetic exactly. Stuck-line cases hold the level well past several timeouts before the output is sampled.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    // Mark-fraction limit expressed as a ratio: excess when high*DEN > period*NUM
    localparam int unsigned RATIO_NUM = 7;
    localparam int unsigned RATIO_DEN = 10;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_WATCH = 2'd1,
        ST_TRIP  = 2'd2
    } guard_state_e;
endpackage

// File: rtl/dtg_sync.sv
module dtg_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev;

    // A rising-edge pulse can never last two cycles (edge timing for R2)
    assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/dtg_meter.sv
module dtg_meter
    import dtg_pkg::*;
#(
    parameter int unsigned TIMEOUT_CLKS = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic rise,
    output logic per_valid,
    output logic per_excess
);
    localparam int unsigned CNT_W  = $clog2(TIMEOUT_CLKS + 1);
    localparam int unsigned TOT_W  = CNT_W + 1;
    localparam int unsigned PROD_W = TOT_W + 4;

    logic [CNT_W-1:0]  hi_cnt;
    logic [CNT_W-1:0]  lo_cnt;
    logic              primed;
    logic [TOT_W-1:0]  total;
    logic [PROD_W-1:0] hi_scaled;
    logic [PROD_W-1:0] tot_scaled;
    logic              over_limit;
    logic              timeout_hit;

    always_comb begin
        total       = {1'b0, hi_cnt} + {1'b0, lo_cnt};
        hi_scaled   = PROD_W'(hi_cnt) * PROD_W'(RATIO_DEN);
        tot_scaled  = PROD_W'(total) * PROD_W'(RATIO_NUM);
        over_limit  = hi_scaled > tot_scaled;
        timeout_hit = total >= TOT_W'(TIMEOUT_CLKS - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt     <= '0;
            lo_cnt     <= '0;
            primed     <= 1'b0;
            per_valid  <= 1'b0;
            per_excess <= 1'b0;
        end else if (rise) begin
            // close the elapsed period; the edge cycle is the first high clock of the next
            per_valid  <= primed;
            per_excess <= primed & over_limit;
            hi_cnt     <= CNT_W'(1);
            lo_cnt     <= '0;
            primed     <= 1'b1;
        end else if (timeout_hit) begin
            // missing edge: synthetic period at the held level
            per_valid  <= 1'b1;
            per_excess <= level;
            hi_cnt     <= '0;
            lo_cnt     <= '0;
            primed     <= 1'b1;
        end else begin
            per_valid  <= 1'b0;
            per_excess <= 1'b0;
            if (level) hi_cnt <= hi_cnt + 1'b1;
            else       lo_cnt <= lo_cnt + 1'b1;
        end
    end

    assert_period_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        total <= TOT_W'(TIMEOUT_CLKS - 1));

    assert_excess_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        per_excess |-> per_valid);
endmodule

// File: rtl/dtg_fsm.sv
module dtg_fsm
    import dtg_pkg::*;
#(
    parameter int unsigned WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             per_valid,
    input  logic             per_excess,
    input  logic             clear,
    input  logic [WIN_W-1:0] window,
    output logic             drive_en,
    output logic             fault
);
    guard_state_e     state, nxt_state;
    logic [WIN_W-1:0] viol_cnt, nxt_cnt;
    logic [WIN_W-1:0] win_eff;
    logic [WIN_W:0]   cnt_inc;
    logic             reach;

    always_comb begin
        win_eff = (window == '0) ? WIN_W'(1) : window;
        cnt_inc = {1'b0, viol_cnt} + 1'b1;
        reach   = cnt_inc >= {1'b0, win_eff};
    end

    always_comb begin
        nxt_state = state;
        nxt_cnt   = viol_cnt;
        if (clear) begin
            nxt_state = ST_RUN;
            nxt_cnt   = '0;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (per_valid && per_excess) begin
                        if (reach) begin
                            nxt_state = ST_TRIP;
                        end else begin
                            nxt_state = ST_WATCH;
                            nxt_cnt   = cnt_inc[WIN_W-1:0];
                        end
                    end
                end
                ST_WATCH: begin
                    if (per_valid) begin
                        if (!per_excess) begin
                            nxt_state = ST_RUN;
                            nxt_cnt   = '0;
                        end else if (reach) begin
                            nxt_state = ST_TRIP;
                        end else begin
                            nxt_cnt   = cnt_inc[WIN_W-1:0];
                        end
                    end
                end
                ST_TRIP: begin
                    nxt_state = ST_TRIP;
                end
                default: begin
                    nxt_state = ST_RUN;
                    nxt_cnt   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            viol_cnt <= '0;
        end else begin
            state    <= nxt_state;
            viol_cnt <= nxt_cnt;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_TRIP: begin drive_en = 1'b0; fault = 1'b1; end
            default: begin drive_en = 1'b1; fault = 1'b0; end
        endcase
    end

    assert_trip_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRIP && !clear) |=> (state == ST_TRIP));

    assert_clear_rearms_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (state == ST_RUN && viol_cnt == '0));

    assert_trip_at_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_TRIP) |-> (({1'b0, $past(viol_cnt)} + 1'b1) >= {1'b0, $past(win_eff)}));

    assert_streak_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (per_valid && !per_excess && !clear && state != ST_TRIP) |=> (state == ST_RUN && viol_cnt == '0));

    assert_no_trip_without_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_TRIP && !per_valid) |=> (state != ST_TRIP));
endmodule

// File: rtl/duty_trip_guard.sv
module duty_trip_guard #(
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned TIMEOUT_CLKS = 8192,
    parameter int unsigned WIN_DEFAULT  = 868
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pwm_in,
    input  logic        win_wr,
    input  logic [15:0] win_val,
    input  logic        clear,
    output logic        drive_en,
    output logic        fault
);
    localparam int unsigned WIN_W = 16;

    logic             level, rise;
    logic             per_valid, per_excess;
    logic [WIN_W-1:0] win_reg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      win_reg <= WIN_W'(WIN_DEFAULT);
        else if (win_wr) win_reg <= win_val;
    end

    dtg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pwm_in),
        .level (level),
        .rise  (rise)
    );

    dtg_meter #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (level),
        .rise       (rise),
        .per_valid  (per_valid),
        .per_excess (per_excess)
    );

    dtg_fsm #(.WIN_W(WIN_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .per_valid  (per_valid),
        .per_excess (per_excess),
        .clear      (clear),
        .window     (win_reg),
        .drive_en   (drive_en),
        .fault      (fault)
    );

    assert_win_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        win_wr |=> (win_reg == $past(win_val)));

    assert_fault_inverse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault != drive_en);
endmodule

// File: tb/sim_duty_trip_guard.sv
`timescale 1ns/1ps
module sim_duty_trip_guard;
    localparam int unsigned TO_CLKS = 64;
    localparam int unsigned WDEF    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwm_in = 1'b0;
    logic        win_wr = 1'b0;
    logic [15:0] win_val = '0;
    logic        clear = 1'b0;
    logic        drive_en, fault;
    int          checks = 0;
    int          failures = 0;

    always #2.5 clk = ~clk;

    duty_trip_guard #(.SYNC_STAGES(2), .TIMEOUT_CLKS(TO_CLKS), .WIN_DEFAULT(WDEF)) u0 (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .win_wr(win_wr),
        .win_val(win_val), .clear(clear), .drive_en(drive_en), .fault(fault)
    );

    typedef struct packed {
        logic [7:0]  hi;
        logic [7:0]  lo;
        logic [7:0]  reps;
        logic [15:0] win;
        logic        trip;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{8'd15, 8'd5,  8'd8,  16'd8, 1'b1},  // R3 75% reaches window
        '{8'd15, 8'd5,  8'd7,  16'd8, 1'b0},  // R3 one short
        '{8'd14, 8'd6,  8'd10, 16'd4, 1'b0},  // R2 exactly 70% compliant
        '{8'd15, 8'd6,  8'd4,  16'd4, 1'b1},  // R2 just above 70%
        '{8'd5,  8'd15, 8'd20, 16'd2, 1'b0},  // R2 low duty
        '{8'd18, 8'd2,  8'd1,  16'd1, 1'b1},  // R3 window one
        '{8'd18, 8'd2,  8'd1,  16'd0, 1'b1},  // R5 window zero acts as one
        '{8'd18, 8'd2,  8'd1,  16'd2, 1'b0}   // R3 single excess tolerated
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic check_state(input string req, input logic exp_trip);
        check(req, fault, exp_trip);
        check(req, drive_en, ~exp_trip);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pwm_in = 1'b0; clear = 1'b0; win_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic load_win(input logic [15:0] w);
        win_val = w; win_wr = 1'b1;
        @(negedge clk);
        win_wr = 1'b0;
    endtask

    task automatic one_period(input int h, input int l);
        pwm_in = 1'b1;
        repeat (h) @(negedge clk);
        pwm_in = 1'b0;
        repeat (l) @(negedge clk);
    endtask

    // rising edge that closes the last period, then wait past sync+meter+fsm latency
    task automatic close_period();
        pwm_in = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic run_periods(input int h, input int l, input int n);
        for (int i = 0; i < n; i++) one_period(h, l);
        close_period();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        // R1 reset state
        do_reset();
        check_state("R1 reset", 1'b0);

        // table walk
        for (int v = 0; v < 8; v++) begin
            do_reset();
            load_win(VECS[v].win);
            run_periods(int'(VECS[v].hi), int'(VECS[v].lo), int'(VECS[v].reps));
            check_state($sformatf("R2/R3/R5/R11 vector %0d", v), VECS[v].trip);
        end

        // R1 default window: 7 excess no trip, 8th trips
        do_reset();
        run_periods(15, 5, 7);
        check_state("R1 default window short", 1'b0);
        run_periods(15, 5, 1);
        check_state("R1 default window reached", 1'b1);

        // R4 compliant period breaks the streak
        do_reset();
        load_win(16'd4);
        for (int i = 0; i < 3; i++) one_period(15, 5);
        one_period(5, 15);
        for (int i = 0; i < 3; i++) one_period(15, 5);
        close_period();
        check_state("R4 streak broken", 1'b0);
        run_periods(15, 5, 1);
        check_state("R4 fourth consecutive trips", 1'b1);

        // R8 sticky through compliant periods and stuck low
        run_periods(5, 15, 5);
        check_state("R8 sticky after compliant", 1'b1);
        pwm_in = 1'b0;
        repeat (200) @(negedge clk);
        check_state("R8 sticky stuck low", 1'b1);

        // R9 clear re-arms with streak zero
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        check_state("R9 clear releases", 1'b0);
        load_win(16'd3);
        run_periods(15, 5, 2);
        check_state("R9 streak restarted", 1'b0);

        // R12 first edge only starts timing: one period with window 1 does not trip
        do_reset();
        load_win(16'd1);
        one_period(18, 2);
        pwm_in = 1'b0;
        repeat (10) @(negedge clk);
        check_state("R12 first edge primes only", 1'b0);

        // R7 stuck low never trips
        repeat (400) @(negedge clk);
        check_state("R7 stuck low", 1'b0);

        // R6 stuck high: window 3 timeouts
        load_win(16'd3);
        pwm_in = 1'b1;
        repeat (150) @(negedge clk);
        check_state("R6 two timeouts not yet", 1'b0);
        repeat (110) @(negedge clk);
        check_state("R6 stuck high trips", 1'b1);

        // R10 inverse relation checked directly
        check("R10 fault inverse", fault, ~drive_en);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule